// File: doc/BRIEF.md
# Indirect-Addressed Event Queue Register Interface

This block is the 16-bit host-facing register file of an Ethernet controller. The host does not address registers directly. It first writes an internal register address into a pointer port. It then reads or writes that register through a data port. Behind the ports are seven configuration registers, five event registers, a read-only identification word and an interrupt status queue. The queue reports the most urgent pending event.

Other logic posts receive, transmit, buffer, receive-miss and collision events as single-cycle pulses. Each pulse carries a shared 10-bit flag field that is merged into the event register. Every register carries its own register number in its low bits, so a value read from the queue identifies its source. Reading an event through the queue retires it. The interrupt line is gated by a bus control bit. It stays high while any event remains pending.

Top module: `evq_regif`

## Requirements
- R1: Host offset 0x0A is the pointer port. A read there returns the pointer. Offset 0x0C is the data port and accesses the register the pointer selects. Reads at any other offset return 0x0000, and writes there (including 0x0E) change nothing.
- R2: After reset, host_rdata is 0x0000 and irq is 0. Read data is registered: host_rdata takes the read value in the cycle after the read strobe and holds it while no read strobe is given.
- R3: Internal address 0x0000 reads 0x630E and ignores writes. Address 0x0002 and unmapped addresses read 0x0000.
- R4: The configuration registers and their fixed codes are 0x0102/0x0003, 0x0104/0x0005, 0x0106/0x0007, 0x010A/0x000B, 0x0112/0x0013, 0x0114/0x0015 and 0x0116/0x0017. Each resets to its code. A write stores the written value ORed with the code.
- R5: The event registers and their numbers are transmit 0x0128/0x0008, receive 0x0124/0x0004, buffer 0x012C/0x000C, receive-miss 0x0130/0x0010 and collision 0x0132/0x0012. Each resets to its number. A post pulse ORs evt_flags shifted left by 6 into bits 15:6 and sets that event's pending flag.
- R6: A read of the queue at 0x0120 returns the first pending event register in the order transmit, receive, buffer, receive-miss, collision. It then clears that pending flag and resets that register to its number. With nothing pending the read returns 0x0000.
- R7: A direct read of the receive, transmit or buffer event register returns its value and resets it to its number, leaving its pending flag unchanged. A direct read of the receive-miss or collision register does not alter it.
- R8: A host write to the queue register clears every pending flag and leaves the event registers' contents unchanged.
- R9: irq rises in the cycle after a post only when bus control bit 15 was already set in the posting cycle. A post with that bit clear leaves irq low. irq falls in the cycle after the pending set becomes empty.
- R10: A data-port write with bit 6 set to 0x0114 is a soft reset. It returns all configuration and event registers, pending flags and irq to their reset values, while 0x0114 itself stores the written value ORed with 0x0015.
- R11: When a post and a clear hit the same event register in one cycle, the post wins: the register holds its number ORed with the new flags and its pending flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_off | input | 4 | Host byte offset of the port accessed |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| evt_tx | input | 1 | Transmit event post pulse |
| evt_rx | input | 1 | Receive event post pulse |
| evt_buf | input | 1 | Buffer event post pulse |
| evt_miss | input | 1 | Receive-miss event post pulse |
| evt_coll | input | 1 | Collision event post pulse |
| evt_flags | input | 10 | Flag bits merged into bits 15:6 of the posted event register |
| irq | output | 1 | Gated interrupt request |

## Verification
A wrong pending flag or priority select shows at the ports on the very next queue read. The returned register number names the wrong source, or a stale value appears where 0x0000 was due. It also shows as irq staying high, or dropping, one cycle after the pop. Corrupted event or configuration contents show as soon as the register is read back, because the fixed low codes must reappear after every clear and soft reset. The bench follows every cycle with its own model, so any disagreement in host_rdata or irq is reported in the cycle it appears.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int WORD_W = 16;
  localparam int FLAG_W = 10;
  localparam int CODE_W = WORD_W - FLAG_W;
  localparam int N_EVT  = 5;
  localparam int N_CFG  = 7;
  localparam int OFF_W  = 4;

  typedef logic [WORD_W-1:0] word_t;

  localparam logic [OFF_W-1:0] OFF_PTR  = 4'hA;
  localparam logic [OFF_W-1:0] OFF_DATA = 4'hC;

  localparam word_t ADDR_PROD  = 16'h0000;
  localparam word_t PROD_ID    = 16'h630E;
  localparam word_t ADDR_QUEUE = 16'h0120;

  // Event slots in priority order: index 0 is served first by the queue.
  localparam word_t EVT_ADDR [N_EVT] = '{16'h0128, 16'h0124, 16'h012C, 16'h0130, 16'h0132};
  localparam word_t EVT_CODE [N_EVT] = '{16'h0008, 16'h0004, 16'h000C, 16'h0010, 16'h0012};
  localparam logic [N_EVT-1:0] EVT_RD_CLR = 5'b00111;

  localparam word_t CFG_ADDR [N_CFG] = '{16'h0102, 16'h0104, 16'h0106, 16'h010A,
                                         16'h0112, 16'h0114, 16'h0116};
  localparam word_t CFG_CODE [N_CFG] = '{16'h0003, 16'h0005, 16'h0007, 16'h000B,
                                         16'h0013, 16'h0015, 16'h0017};
  localparam int CFG_SELF     = 5;
  localparam int CFG_BUS      = 6;
  localparam int SOFT_RST_BIT = 6;
  localparam int IRQ_GATE_BIT = 15;
endpackage

// File: rtl/evq_cfg_bank.sv
module evq_cfg_bank
  import evq_pkg::*;
#(
  parameter int N = N_CFG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         wr_sel,
  input  word_t                wdata,
  input  logic                 soft_rst,
  output logic [N-1:0][WORD_W-1:0] val
);

  for (genvar g = 0; g < N; g++) begin : g_reg
    word_t q, d;
    logic  en;

    always_comb begin
      en = wr_sel[g] | soft_rst;
      if (wr_sel[g]) d = wdata | CFG_CODE[g];
      else           d = CFG_CODE[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= CFG_CODE[g];
      else if (en) q <= d;
    end

    assign val[g] = q;
  end

endmodule

// File: rtl/evq_event_bank.sv
module evq_event_bank
  import evq_pkg::*;
#(
  parameter int N  = N_EVT,
  parameter int FW = FLAG_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             post,
  input  logic [FW-1:0]            flags,
  input  logic [N-1:0]             rd_clr,
  input  logic                     pop,
  input  logic                     flush,
  input  logic                     soft_rst,
  output logic [N-1:0][WORD_W-1:0] val,
  output logic [N-1:0]             pend_q,
  output logic [N-1:0]             pend_d,
  output word_t                    head
);
  localparam int CW = WORD_W - FW;

  logic [N-1:0] sel;
  logic [N-1:0] clr;

  // Fixed-priority pick of the first pending slot.
  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_q[i] && !found) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    head = '0;
    for (int i = 0; i < N; i++)
      if (sel[i]) head = head | val[i];
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      clr[i] = rd_clr[i] | (pop & sel[i]);
      if (soft_rst)
        pend_d[i] = 1'b0;
      else
        pend_d[i] = ((flush | (pop & sel[i])) ? 1'b0 : pend_q[i]) | post[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  for (genvar g = 0; g < N; g++) begin : g_evt
    logic [FW-1:0] hi_q, hi_d;
    logic          en;

    always_comb begin
      en = soft_rst | clr[g] | post[g];
      if (soft_rst) hi_d = '0;
      else          hi_d = (clr[g] ? '0 : hi_q) | (post[g] ? flags : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  hi_q <= '0;
      else if (en) hi_q <= hi_d;
    end

    assign val[g] = {hi_q, EVT_CODE[g][CW-1:0]};
  end

endmodule

// File: rtl/evq_regif.sv
module evq_regif
  import evq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [3:0]        host_off,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic              evt_tx,
  input  logic              evt_rx,
  input  logic              evt_buf,
  input  logic              evt_miss,
  input  logic              evt_coll,
  input  logic [9:0]        evt_flags,
  output logic              irq
);

  word_t ptr_q, ptr_d;
  word_t rdata_q, rd_val;
  logic  irq_q, irq_d;

  logic wr_ptr, wr_data, rd_data;
  logic soft_rst, pop, flush;

  logic [N_CFG-1:0]             cfg_wr;
  logic [N_CFG-1:0][WORD_W-1:0] cfg_val;
  logic [N_EVT-1:0]             post, rd_clr, pend_q, pend_d;
  logic [N_EVT-1:0][WORD_W-1:0] evt_val;
  word_t                        head;

  assign post = {evt_coll, evt_miss, evt_buf, evt_rx, evt_tx};

  // Port decode
  always_comb begin
    wr_ptr   = host_wr && (host_off == OFF_PTR);
    wr_data  = host_wr && (host_off == OFF_DATA);
    rd_data  = host_rd && (host_off == OFF_DATA);
    pop      = rd_data && (ptr_q == ADDR_QUEUE);
    flush    = wr_data && (ptr_q == ADDR_QUEUE);
    soft_rst = wr_data && (ptr_q == CFG_ADDR[CFG_SELF]) && host_wdata[SOFT_RST_BIT];
    for (int i = 0; i < N_CFG; i++)
      cfg_wr[i] = wr_data && (ptr_q == CFG_ADDR[i]);
    for (int i = 0; i < N_EVT; i++)
      rd_clr[i] = rd_data && (ptr_q == EVT_ADDR[i]) && EVT_RD_CLR[i];
  end

  evq_cfg_bank #(.N(N_CFG)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_sel   (cfg_wr),
    .wdata    (host_wdata),
    .soft_rst (soft_rst),
    .val      (cfg_val)
  );

  evq_event_bank #(.N(N_EVT), .FW(FLAG_W)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .post     (post),
    .flags    (evt_flags),
    .rd_clr   (rd_clr),
    .pop      (pop),
    .flush    (flush),
    .soft_rst (soft_rst),
    .val      (evt_val),
    .pend_q   (pend_q),
    .pend_d   (pend_d),
    .head     (head)
  );

  // Read mux
  always_comb begin
    rd_val = '0;
    if (host_off == OFF_PTR) begin
      rd_val = ptr_q;
    end else if (host_off == OFF_DATA) begin
      if (ptr_q == ADDR_PROD)  rd_val = PROD_ID;
      if (ptr_q == ADDR_QUEUE) rd_val = head;
      for (int i = 0; i < N_CFG; i++)
        if (ptr_q == CFG_ADDR[i]) rd_val = cfg_val[i];
      for (int i = 0; i < N_EVT; i++)
        if (ptr_q == EVT_ADDR[i]) rd_val = evt_val[i];
    end
  end

  // Next state
  always_comb begin
    ptr_d = wr_ptr ? host_wdata : ptr_q;
    if (soft_rst)
      irq_d = 1'b0;
    else
      irq_d = (irq_q | ((|post) & cfg_val[CFG_BUS][IRQ_GATE_BIT])) & (|pend_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_ptr)  ptr_q   <= ptr_d;
      if (host_rd) rdata_q <= rd_val;
      irq_q <= irq_d;
    end
  end

  assign host_rdata = rdata_q;
  assign irq        = irq_q;

endmodule

// File: rtl/evq_regif_chk.sv
module evq_regif_chk
  import evq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic             host_rd,
  input logic [3:0]       host_off,
  input logic [15:0]      host_rdata,
  input logic             irq,
  input logic [N_EVT-1:0] post,
  input logic [15:0]      ptr,
  input logic [N_EVT-1:0] pend,
  input logic             gate
);

  // R9
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != '0));

  // R9
  irq_rise_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(gate && (post != '0)));

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

  // R3
  prod_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_off == OFF_DATA && ptr == ADDR_PROD) |=> host_rdata == PROD_ID);

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_off == OFF_DATA && ptr == ADDR_QUEUE && post == '0) |=> pend == '0);

  // R6
  pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_off == OFF_DATA && ptr == ADDR_QUEUE &&
     post == '0 && pend != '0)
    |=> $countones(pend) == $countones($past(pend)) - 1);

endmodule

bind evq_regif evq_regif_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_off   (host_off),
  .host_rdata (host_rdata),
  .irq        (irq),
  .post       (post),
  .ptr        (ptr_q),
  .pend       (pend_q),
  .gate       (cfg_val[CFG_BUS][IRQ_GATE_BIT])
);

// File: tb/tb_evq_regif.sv
`timescale 1ns/1ps
module tb_evq_regif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0]  host_off = 4'h0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        evt_tx = 0, evt_rx = 0, evt_buf = 0, evt_miss = 0, evt_coll = 0;
  logic [9:0]  evt_flags = 10'h0;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evq_regif dut (.*);

  // ---------------- behavioural reference model ----------------
  logic [15:0] mr [int];
  bit          mp [int];
  int          prio [5] = '{'h128, 'h124, 'h12C, 'h130, 'h132};
  int          m_ptr;
  logic [15:0] m_rdata;
  bit          m_irq;
  logic [15:0] v;
  bit          gate, posted, sreset, anyp, hit;

  function automatic logic [15:0] code_of(int a);
    case (a)
      'h102: return 16'h3;   'h104: return 16'h5;   'h106: return 16'h7;
      'h10A: return 16'hB;   'h112: return 16'h13;  'h114: return 16'h15;
      'h116: return 16'h17;  'h124: return 16'h4;   'h128: return 16'h8;
      'h12C: return 16'hC;   'h130: return 16'h10;  'h132: return 16'h12;
      default: return 16'h0;
    endcase
  endfunction

  function automatic bit is_cfg(int a);
    return (a >= 'h102 && a <= 'h116 && code_of(a) != 0);
  endfunction

  task automatic m_defaults();
    foreach (prio[k]) begin mr[prio[k]] = code_of(prio[k]); mp[prio[k]] = 0; end
    for (int a = 'h102; a <= 'h116; a += 2) if (is_cfg(a)) mr[a] = code_of(a);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_rdata = 0; m_irq = 0; m_defaults();
    end else begin
      gate = mr['h116][15]; posted = 0; sreset = 0;
      if (host_rd) begin
        v = 0;
        if (host_off == 4'hA) v = m_ptr[15:0];
        else if (host_off == 4'hC) begin
          if (m_ptr == 0) v = 16'h630E;
          else if (m_ptr == 'h120) begin
            hit = 0;
            foreach (prio[k]) if (!hit && mp[prio[k]]) begin
              hit = 1; v = mr[prio[k]]; mr[prio[k]] = code_of(prio[k]); mp[prio[k]] = 0;
            end
          end else if (mr.exists(m_ptr)) begin
            v = mr[m_ptr];
            if (m_ptr == 'h124 || m_ptr == 'h128 || m_ptr == 'h12C) mr[m_ptr] = code_of(m_ptr);
          end
        end
        m_rdata = v;
      end
      if (host_wr) begin
        if (host_off == 4'hA) m_ptr = int'(host_wdata);
        else if (host_off == 4'hC) begin
          if (m_ptr == 'h120) foreach (prio[k]) mp[prio[k]] = 0;
          else if (m_ptr == 'h114 && host_wdata[6]) begin
            m_defaults(); sreset = 1; mr['h114] = host_wdata | 16'h15;
          end else if (is_cfg(m_ptr)) mr[m_ptr] = host_wdata | code_of(m_ptr);
        end
      end
      if (!sreset) begin
        if (evt_tx)   begin mr['h128] |= {evt_flags, 6'b0}; mp['h128] = 1; posted = 1; end
        if (evt_rx)   begin mr['h124] |= {evt_flags, 6'b0}; mp['h124] = 1; posted = 1; end
        if (evt_buf)  begin mr['h12C] |= {evt_flags, 6'b0}; mp['h12C] = 1; posted = 1; end
        if (evt_miss) begin mr['h130] |= {evt_flags, 6'b0}; mp['h130] = 1; posted = 1; end
        if (evt_coll) begin mr['h132] |= {evt_flags, 6'b0}; mp['h132] = 1; posted = 1; end
      end
      anyp = 0;
      foreach (prio[k]) anyp |= mp[prio[k]];
      m_irq = sreset ? 0 : ((m_irq | (posted & gate)) & anyp);
    end
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    checks += 2;
    if (host_rdata !== m_rdata) begin
      errors++; $display("FAIL R2 model: host_rdata=%h expected %h at %0t", host_rdata, m_rdata, $time);
    end
    if (irq !== m_irq) begin
      errors++; $display("FAIL R9 model: irq=%b expected %b at %0t", irq, m_irq, $time);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++; $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic hw(input logic [3:0] o, input logic [15:0] d);
    @(negedge clk); host_wr = 1; host_off = o; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hr(input logic [3:0] o, output logic [15:0] d);
    @(negedge clk); host_rd = 1; host_off = o;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  task automatic reg_wr(input logic [15:0] a, input logic [15:0] d);
    hw(4'hA, a); hw(4'hC, d);
  endtask

  task automatic reg_rd(input logic [15:0] a, output logic [15:0] d);
    hw(4'hA, a); hr(4'hC, d);
  endtask

  task automatic drive_post(input logic [4:0] m, input logic [9:0] f);
    evt_tx = m[0]; evt_rx = m[1]; evt_buf = m[2]; evt_miss = m[3]; evt_coll = m[4];
    evt_flags = f;
  endtask

  task automatic post(input logic [4:0] m, input logic [9:0] f);
    @(negedge clk); drive_post(m, f);
    @(negedge clk); drive_post(5'b0, 10'h0);
  endtask

  // queue read with a post in the same cycle (pointer must already be the queue)
  task automatic pop_with_post(input logic [4:0] m, input logic [9:0] f, output logic [15:0] d);
    @(negedge clk); host_rd = 1; host_off = 4'hC; drive_post(m, f);
    @(negedge clk); host_rd = 0; drive_post(5'b0, 10'h0); d = host_rdata;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    chk("R2 reset rdata", host_rdata, 16'h0);
    chk("R9 reset irq", {15'b0, irq}, 16'h0);
    rst_n = 1;

    // R3 identification word
    reg_rd(16'h0000, r); chk("R3 product id", r, 16'h630E);
    reg_wr(16'h0000, 16'h1234); reg_rd(16'h0000, r); chk("R3 id ignores write", r, 16'h630E);
    reg_rd(16'h0002, r); chk("R3 upper id word", r, 16'h0000);
    reg_rd(16'h0200, r); chk("R3 unmapped", r, 16'h0000);

    // R1 port decode
    hw(4'hA, 16'h0104); hr(4'hA, r); chk("R1 pointer readback", r, 16'h0104);
    hw(4'hE, 16'hFFFF); hr(4'hC, r); chk("R1 write at 0x0E ignored", r, 16'h0005);
    hr(4'h0, r); chk("R1 other offset reads zero", r, 16'h0000);

    // R2 hold
    @(negedge clk); chk("R2 rdata holds when idle", host_rdata, 16'h0000);

    // R4 configuration
    reg_rd(16'h0102, r); chk("R4 rx cfg default", r, 16'h0003);
    reg_rd(16'h0112, r); chk("R4 line ctl default", r, 16'h0013);
    reg_rd(16'h0116, r); chk("R4 bus ctl default", r, 16'h0017);
    reg_wr(16'h0102, 16'h0100); reg_rd(16'h0102, r); chk("R4 write OR code", r, 16'h0103);
    reg_wr(16'h0102, 16'h0004); reg_rd(16'h0102, r); chk("R4 low bits OR code", r, 16'h0007);
    reg_wr(16'h010A, 16'h8800); reg_rd(16'h010A, r); chk("R4 buf cfg", r, 16'h880B);

    // R5 post with gate clear, R9 no irq
    post(5'b01000, 10'h001);
    chk("R9 no irq with gate clear", {15'b0, irq}, 16'h0);
    reg_rd(16'h0130, r); chk("R5 miss flags merged", r, 16'h0050);
    reg_rd(16'h0130, r); chk("R7 miss read does not clear", r, 16'h0050);
    reg_rd(16'h0120, r); chk("R6 queue returns miss", r, 16'h0050);
    hr(4'hC, r); chk("R6 empty queue reads zero", r, 16'h0000);

    // R9 gate on, R6 priority
    reg_wr(16'h0116, 16'h8000); reg_rd(16'h0116, r); chk("R4 bus ctl gate", r, 16'h8017);
    post(5'b00001, 10'h004);
    chk("R9 irq after gated post", {15'b0, irq}, 16'h1);
    post(5'b10110, 10'h004);
    hw(4'hA, 16'h0120);
    hr(4'hC, r); chk("R6 first is transmit", r, 16'h0108);
    hr(4'hC, r); chk("R6 second is receive", r, 16'h0104);
    hr(4'hC, r); chk("R6 third is buffer", r, 16'h010C);
    chk("R9 irq while pending", {15'b0, irq}, 16'h1);
    hr(4'hC, r); chk("R6 fourth is collision", r, 16'h0112);
    chk("R9 irq drops when empty", {15'b0, irq}, 16'h0);
    hr(4'hC, r); chk("R6 drained queue", r, 16'h0000);

    // R7 direct read clears but keeps pending
    post(5'b00010, 10'h200);
    reg_rd(16'h0124, r); chk("R7 direct rx read", r, 16'h8004);
    reg_rd(16'h0124, r); chk("R7 rx reset to number", r, 16'h0004);
    chk("R7 pending kept irq", {15'b0, irq}, 16'h1);
    reg_rd(16'h0120, r); chk("R7 queue after direct read", r, 16'h0004);
    chk("R9 irq low after pop", {15'b0, irq}, 16'h0);

    // R8 flush
    post(5'b00101, 10'h001);
    chk("R9 irq before flush", {15'b0, irq}, 16'h1);
    reg_wr(16'h0120, 16'h0000);
    chk("R8 irq cleared by flush", {15'b0, irq}, 16'h0);
    hr(4'hC, r); chk("R8 queue empty after flush", r, 16'h0000);
    reg_rd(16'h012C, r); chk("R8 buffer contents kept", r, 16'h004C);
    reg_rd(16'h0128, r); chk("R8 transmit contents kept", r, 16'h0048);

    // R11 post and pop same cycle
    post(5'b00010, 10'h001);
    hw(4'hA, 16'h0120);
    pop_with_post(5'b00010, 10'h002, r); chk("R11 pop value", r, 16'h0044);
    chk("R11 pending survives", {15'b0, irq}, 16'h1);
    hr(4'hC, r); chk("R11 post wins", r, 16'h0084);

    // R10 soft reset
    reg_wr(16'h0102, 16'h0100);
    post(5'b00001, 10'h001);
    reg_wr(16'h0114, 16'h0040);
    chk("R10 irq cleared", {15'b0, irq}, 16'h0);
    reg_rd(16'h0114, r); chk("R10 self ctl stores write", r, 16'h0055);
    reg_rd(16'h0102, r); chk("R10 rx cfg default", r, 16'h0003);
    reg_rd(16'h0116, r); chk("R10 bus ctl default", r, 16'h0017);
    reg_rd(16'h0120, r); chk("R10 no pending", r, 16'h0000);
    reg_rd(16'h0128, r); chk("R10 transmit number", r, 16'h0008);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule